// File: doc/BRIEF.md
# Lane Test Pattern Multiplexer

This block sits on one serial lane between the 8b/10b encoder and the serializer. On every clock it emits one 10-bit line symbol. In normal operation that symbol is the already encoded link data. For link-quality and jitter testing it can instead emit one of several fixed or generated patterns: a high-frequency alternating symbol, a disparity-balanced comma character, a pass-through of an externally built lane-alignment symbol stream, a 24-symbol random-pattern table, or a pseudo-random bit sequence of selectable order. The test patterns are already in line-code form and never go through the encoder.

A 3-bit mode input selects the source and a 2-bit order input selects the PRBS polynomial. The block is built around a small state machine whose states are ST_NORMAL, ST_D215, ST_K285, ST_ILA, ST_RPAT and ST_PRBS. Every clock the next state is decoded from the mode input. Any state can move to any other, and each transition is named for its target: "go normal" (mode 0, 5 or 7), "go D21.5" (mode 1), "go K28.5" (mode 2), "go lane alignment" (mode 3), "go RPAT" (mode 4) and "go PRBS" (mode 6). A transition into a stateful pattern, or a change of PRBS order while in ST_PRBS, counts as an entry and restarts that pattern from its start point. The output symbol is registered, so the symbol selected by the inputs at one clock edge appears on the output after that edge.

Symbol bit 9 is the first bit on the line.

Top module: `lane_pattern_mux`

## Requirements
- R1: While rst_n is low, sym_o is 10'b0000000000 and the machine is held in ST_NORMAL.
- R2: With mode_i equal to 0, 5 or 7, sym_o equals the enc_data_i value sampled at the previous rising edge.
- R3: With mode_i equal to 1, sym_o is the D21.5 symbol 10'b1010101010 on every cycle.
- R4: With mode_i equal to 2, sym_o alternates between the comma symbols 10'b0011111010 and 10'b1100000101. The first symbol after entry is 10'b0011111010.
- R5: With mode_i equal to 3, sym_o equals the ila_sym_i value sampled at the previous rising edge.
- R6: With mode_i equal to 4, sym_o steps through the 24-entry RPAT symbol table one entry per clock, starting at entry 0 on entry. It wraps from entry 23 back to entry 0. The entries in order, in hex, are 1E8 2A5 0F1 31A 14B 2D2 0B7 34C 1A6 259 0CE 331 217 15A 30E 0E5 2B4 14D 363 09C 1D2 22D 0AB 354.
- R7: With mode_i equal to 6, sym_o carries ten new PRBS bits per clock, first bit in bit 9. prbs_order_i selects the polynomial: 0 gives x^7+x^6+1, 1 gives x^15+x^14+1, 2 gives x^23+x^18+1 and 3 gives x^31+x^28+1. Each new bit is the XOR of the bits produced n and k steps earlier, where the polynomial is x^n+x^k+1.
- R8: Entering mode 2, 4 or 6 restarts the pattern. For the comma this means the first symbol; for RPAT, entry 0; for PRBS, a register of all ones. A change of prbs_order_i while in mode 6 also counts as an entry.
- R9: The output is registered: the symbol chosen from the inputs at one rising edge appears on sym_o right after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Pattern mode select |
| prbs_order_i | input | 2 | PRBS polynomial select |
| enc_data_i | input | 10 | Encoded link data symbol |
| ila_sym_i | input | 10 | Lane-alignment symbol stream from the alignment generator |
| sym_o | output | 10 | Line symbol to the serializer |

## Verification
The assertions assume that mode_i, enc_data_i and ila_sym_i are steady around each rising edge, and that the symbol they select depends only on the values sampled at that edge. The stimulus changes every input only on the falling clock edge. The comma check assumes that two consecutive samples of mode 2 make a continuing run, so the stimulus includes runs in which mode 2 is left and re-entered, to confirm the restart. All PRBS orders are driven long enough to pass the shortest register length several times, and the order is changed while mode 6 stays selected.

// File: rtl/lane_pattern_pkg.sv
package lane_pattern_pkg;

    localparam int SYM_W    = 10;
    localparam int MODE_W   = 3;
    localparam int ORD_W    = 2;
    localparam int RPAT_LEN = 24;
    localparam int RPAT_IW  = $clog2(RPAT_LEN);

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_D215   = 3'd1,
        ST_K285   = 3'd2,
        ST_ILA    = 3'd3,
        ST_RPAT   = 3'd4,
        ST_PRBS   = 3'd5
    } lane_state_e;

    localparam logic [SYM_W-1:0] SYM_D215  = 10'b1010101010;
    localparam logic [SYM_W-1:0] SYM_K_NEG = 10'b0011111010;
    localparam logic [SYM_W-1:0] SYM_K_POS = 10'b1100000101;

    function automatic lane_state_e decode_mode(input logic [MODE_W-1:0] m);
        lane_state_e s;
        unique case (m)
            3'd1:    s = ST_D215;
            3'd2:    s = ST_K285;
            3'd3:    s = ST_ILA;
            3'd4:    s = ST_RPAT;
            3'd6:    s = ST_PRBS;
            default: s = ST_NORMAL;
        endcase
        return s;
    endfunction

    function automatic int prbs_len(input int ord);
        int n;
        case (ord)
            0:       n = 7;
            1:       n = 15;
            2:       n = 23;
            default: n = 31;
        endcase
        return n;
    endfunction

    function automatic int prbs_tap(input int ord);
        int k;
        case (ord)
            0:       k = 6;
            1:       k = 14;
            2:       k = 18;
            default: k = 28;
        endcase
        return k;
    endfunction

    function automatic logic [SYM_W-1:0] rpat_sym(input logic [RPAT_IW-1:0] idx);
        logic [SYM_W-1:0] v;
        case (idx)
            5'd0:    v = 10'h1E8;
            5'd1:    v = 10'h2A5;
            5'd2:    v = 10'h0F1;
            5'd3:    v = 10'h31A;
            5'd4:    v = 10'h14B;
            5'd5:    v = 10'h2D2;
            5'd6:    v = 10'h0B7;
            5'd7:    v = 10'h34C;
            5'd8:    v = 10'h1A6;
            5'd9:    v = 10'h259;
            5'd10:   v = 10'h0CE;
            5'd11:   v = 10'h331;
            5'd12:   v = 10'h217;
            5'd13:   v = 10'h15A;
            5'd14:   v = 10'h30E;
            5'd15:   v = 10'h0E5;
            5'd16:   v = 10'h2B4;
            5'd17:   v = 10'h14D;
            5'd18:   v = 10'h363;
            5'd19:   v = 10'h09C;
            5'd20:   v = 10'h1D2;
            5'd21:   v = 10'h22D;
            5'd22:   v = 10'h0AB;
            5'd23:   v = 10'h354;
            default: v = 10'h1E8;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lane_lfsr_word.sv
module lane_lfsr_word #(
    parameter int N     = 7,
    parameter int K     = 6,
    parameter int WORD  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            advance,
    output logic [WORD-1:0] word
);

    logic [N-1:0] st_q;
    logic [N-1:0] st_end;

    always_comb begin
        logic [N-1:0] cur;
        logic         nb;
        cur  = restart ? {N{1'b1}} : st_q;
        word = '0;
        for (int i = 0; i < WORD; i++) begin
            nb              = cur[N-1] ^ cur[K-1];
            word[WORD-1-i]  = nb;
            cur             = {cur[N-2:0], nb};
        end
        st_end = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= {N{1'b1}};
        end else if (advance) begin
            st_q <= st_end;
        end
    end

endmodule

// File: rtl/lane_prbs_bank.sv
module lane_prbs_bank
    import lane_pattern_pkg::*;
#(
    parameter int WORD   = SYM_W,
    parameter int N_ORD  = 4,
    localparam int OW    = $clog2(N_ORD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            advance,
    input  logic [OW-1:0]   order,
    output logic [WORD-1:0] word
);

    logic [WORD-1:0] words [N_ORD];

    for (genvar g = 0; g < N_ORD; g++) begin : g_ord
        logic sel;
        assign sel = (order == OW'(g));
        lane_lfsr_word #(
            .N    (prbs_len(g)),
            .K    (prbs_tap(g)),
            .WORD (WORD)
        ) i_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart && sel),
            .advance (advance && sel),
            .word    (words[g])
        );
    end

    assign word = words[order];

endmodule

// File: rtl/lane_rpat_seq.sv
module lane_rpat_seq
    import lane_pattern_pkg::*;
#(
    parameter int LEN = RPAT_LEN,
    localparam int IW = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    output logic [SYM_W-1:0] sym
);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_use;

    assign idx_use = restart ? '0 : idx_q;
    assign sym     = rpat_sym(RPAT_IW'(idx_use));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= (idx_use == IW'(LEN - 1)) ? '0 : idx_use + 1'b1;
        end
    end

endmodule

// File: rtl/lane_pattern_mux.sv
module lane_pattern_mux
    import lane_pattern_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ORD_W-1:0]  prbs_order_i,
    input  logic [SYM_W-1:0]  enc_data_i,
    input  logic [SYM_W-1:0]  ila_sym_i,
    output logic [SYM_W-1:0]  sym_o
);

    lane_state_e       st_q, st_d;
    logic [ORD_W-1:0]  ord_q;
    logic              k_ph_q;
    logic              k_use;
    logic              enter;
    logic              reorder;
    logic [SYM_W-1:0]  prbs_word;
    logic [SYM_W-1:0]  rpat_word;
    logic [SYM_W-1:0]  sym_d;
    logic [SYM_W-1:0]  sym_q;

    assign st_d    = decode_mode(mode_i);
    assign reorder = (st_d == ST_PRBS) && (prbs_order_i != ord_q);
    assign enter   = (st_d != st_q) || reorder;
    assign k_use   = enter ? 1'b0 : k_ph_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_NORMAL;
            ord_q  <= '0;
            k_ph_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ord_q <= prbs_order_i;
            if (st_d == ST_K285) begin
                k_ph_q <= ~k_use;
            end
        end
    end

    lane_rpat_seq #(.LEN(RPAT_LEN)) i_rpat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (enter),
        .advance (st_d == ST_RPAT),
        .sym     (rpat_word)
    );

    lane_prbs_bank #(.WORD(SYM_W), .N_ORD(1 << ORD_W)) i_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (enter),
        .advance (st_d == ST_PRBS),
        .order   (prbs_order_i),
        .word    (prbs_word)
    );

    // outputs
    always_comb begin
        unique case (st_d)
            ST_NORMAL: sym_d = enc_data_i;
            ST_D215:   sym_d = SYM_D215;
            ST_K285:   sym_d = k_use ? SYM_K_POS : SYM_K_NEG;
            ST_ILA:    sym_d = ila_sym_i;
            ST_RPAT:   sym_d = rpat_word;
            ST_PRBS:   sym_d = prbs_word;
            default:   sym_d = enc_data_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else begin
            sym_q <= sym_d;
        end
    end

    assign sym_o = sym_q;

endmodule

// File: rtl/lane_pattern_mux_chk.sv
module lane_pattern_mux_chk
    import lane_pattern_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic [ORD_W-1:0]  prbs_order_i,
    input logic [SYM_W-1:0]  enc_data_i,
    input logic [SYM_W-1:0]  ila_sym_i,
    input logic [SYM_W-1:0]  sym_o
);

    // R2
    normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_i) == 3'd0 || $past(mode_i) == 3'd5 || $past(mode_i) == 3'd7))
        |-> (sym_o == $past(enc_data_i)));

    // R3
    d215_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 3'd1) |-> (sym_o == 10'b1010101010));

    // R4
    comma_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(mode_i) == 3'd2 && $past(mode_i, 2) == 3'd2)
        |-> (sym_o != $past(sym_o) && (sym_o == 10'b0011111010 || sym_o == 10'b1100000101)));

    // R5
    ila_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == 3'd3) |-> (sym_o == $past(ila_sym_i)));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        ($past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 && !rst_n) |-> (sym_o == '0));

endmodule

bind lane_pattern_mux lane_pattern_mux_chk i_chk (.*);

// File: tb/test_lane_pattern_mux.sv
module test_lane_pattern_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic [1:0] prbs_order_i = 2'd0;
    logic [9:0] enc_data_i = '0;
    logic [9:0] ila_sym_i = '0;
    logic [9:0] sym_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    lane_pattern_mux i_lane_pattern_mux (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .prbs_order_i(prbs_order_i),
        .enc_data_i(enc_data_i), .ila_sym_i(ila_sym_i), .sym_o(sym_o)
    );

    // reference model state
    int         rpat_tbl [24] = '{'h1E8,'h2A5,'h0F1,'h31A,'h14B,'h2D2,'h0B7,'h34C,
                                   'h1A6,'h259,'h0CE,'h331,'h217,'h15A,'h30E,'h0E5,
                                   'h2B4,'h14D,'h363,'h09C,'h1D2,'h22D,'h0AB,'h354};
    int         prev_cls = 0;
    int         prev_ord = 0;
    int         kph = 0;
    int         ridx = 0;
    bit         hist[$];
    logic [9:0] exp_sym = '0;
    string      exp_tag = "R1";
    bit         have_exp = 0;

    function automatic int cls_of(input logic [2:0] m);
        if (m == 3'd1 || m == 3'd2 || m == 3'd3 || m == 3'd4 || m == 3'd6) return int'(m);
        return 0;
    endfunction

    // R9: model computes at the rising edge the symbol that appears right after it
    always @(posedge clk) begin
        int  c;
        int  n;
        int  k;
        bit  ent;
        bit  nb;
        if (!rst_n) begin
            exp_sym  = '0;
            exp_tag  = "R1";
            prev_cls = 0;
            prev_ord = 0;
            kph      = 0;
            ridx     = 0;
        end else begin
            c   = cls_of(mode_i);
            ent = (c != prev_cls) || (c == 6 && int'(prbs_order_i) != prev_ord);
            exp_tag = (ent && (c == 2 || c == 4 || c == 6)) ? "R8" :
                      (c == 1) ? "R3" : (c == 2) ? "R4" : (c == 3) ? "R5" :
                      (c == 4) ? "R6" : (c == 6) ? "R7" : "R2/R9";
            case (c)
                1: exp_sym = 10'b1010101010;
                2: begin
                    if (ent) kph = 0;
                    exp_sym = (kph == 0) ? 10'b0011111010 : 10'b1100000101;
                    kph = 1 - kph;
                end
                3: exp_sym = ila_sym_i;
                4: begin
                    if (ent) ridx = 0;
                    exp_sym = 10'(rpat_tbl[ridx]);
                    ridx = (ridx + 1) % 24;
                end
                6: begin
                    case (prbs_order_i)
                        2'd0: begin n = 7;  k = 6;  end
                        2'd1: begin n = 15; k = 14; end
                        2'd2: begin n = 23; k = 18; end
                        default: begin n = 31; k = 28; end
                    endcase
                    if (ent) begin
                        hist.delete();
                        for (int i = 0; i < 31; i++) hist.push_back(1'b1);
                    end
                    for (int i = 0; i < 10; i++) begin
                        nb = hist[hist.size() - n] ^ hist[hist.size() - k];
                        exp_sym[9 - i] = nb;
                        hist.push_back(nb);
                        void'(hist.pop_front());
                    end
                end
                default: exp_sym = enc_data_i;
            endcase
            prev_cls = c;
            prev_ord = int'(prbs_order_i);
        end
        have_exp = 1;
    end

    always @(negedge clk) begin
        cycles++;
        if (have_exp && !done) begin
            n_cmp++;
            if (sym_o !== exp_sym) begin
                n_bad++;
                $display("FAIL %s: sym_o=%h expected %h (mode %0d)", exp_tag, sym_o, exp_sym, mode_i);
            end
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(input logic [2:0] m, input logic [1:0] o, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mode_i       = m;
            prbs_order_i = o;
            enc_data_i   = 10'($urandom);
            ila_sym_i    = 10'($urandom);
        end
    endtask

    initial begin
        run(3'd0, 2'd0, 4);           // R1 reset held
        @(negedge clk) rst_n = 1'b1;
        run(3'd0, 2'd0, 20);          // R2
        run(3'd1, 2'd0, 10);          // R3
        run(3'd2, 2'd0, 11);          // R4
        run(3'd3, 2'd0, 12);          // R5
        run(3'd4, 2'd0, 55);          // R6 wraps twice
        run(3'd6, 2'd0, 40);          // R7 order 0
        run(3'd6, 2'd1, 40);          // R8 order change reseed
        run(3'd6, 2'd2, 40);
        run(3'd6, 2'd3, 40);
        run(3'd5, 2'd3, 8);           // R2 unused code
        run(3'd7, 2'd1, 8);
        run(3'd6, 2'd0, 12);          // R8 re-entry
        run(3'd2, 2'd0, 3);           // R8 comma restart
        run(3'd1, 2'd0, 1);
        run(3'd2, 2'd0, 4);
        run(3'd4, 2'd0, 5);           // R8 RPAT restart
        run(3'd3, 2'd0, 2);
        run(3'd4, 2'd0, 5);
        @(negedge clk) rst_n = 1'b0;  // R1 mid-run reset
        run(3'd6, 2'd1, 3);
        @(negedge clk) rst_n = 1'b1;
        run(3'd6, 2'd1, 20);
        run(3'd0, 2'd0, 4);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule